// File: doc/BRIEF.md
# Bus Master Read-Cycle Sequencer

This block sits on the master side of a small shared bus. It runs one read transaction at a time. The bus has a 2-bit address that selects one of four devices and a single data line. A read is started by a one-cycle request that carries the target address. The sequencer first drives that address and holds it for an address setup interval. It then pulls the active-low read strobe low. The falling edge of the strobe starts the transfer timing. The strobe stays low for the full device access window, the data bit is captured on the last cycle of that window, and the strobe is released. The address is held through a post-strobe hold interval, and then the captured bit is reported with a one-cycle completion pulse.

All three intervals are given in nanoseconds and turned into clock-cycle counts from a clock-period parameter. Each count is rounded up, so the bus timing is always met or exceeded. A request that arrives while a transaction is in progress is dropped. The sequencer never queues work.

Top module: `busReadSeq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rdStrobeN` is 1 and `busy`, `done`, `busAddr` and `dataOut` are all 0.
- R2: When `start` is sampled high while idle, the next clock edge loads `startAddr` onto `busAddr` and raises `busy`, and `rdStrobeN` stays 1.
- R3: `rdStrobeN` falls exactly SETUP_CYC clock edges after the edge that loaded the address. This is 10 at the default 10 ns period with a 100 ns setup.
- R4: `rdStrobeN` stays low for exactly ACCESS_CYC cycles. This is 55 for 550 ns at 10 ns. The data bit is sampled on the edge where the strobe returns high, and is never sampled earlier.
- R5: `done` goes high HOLD_CYC edges after the strobe rises and stays high for exactly one cycle. The default is 1 edge for 5 ns. During that cycle `dataOut` shows the captured bit, and it keeps that bit until the next capture.
- R6: `busAddr` does not change from the loading edge until the next accepted request. This covers the setup, strobe-low, hold and done cycles.
- R7: `start` is ignored whenever `busy` is 1, including the `done` cycle. `busy` falls on the edge after the `done` cycle.
- R8: Each interval count is ceil(ns / CLK_PERIOD_NS), with a minimum of one cycle. The strobe is driven only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a read |
| startAddr | input | 2 | Target device number taken with `start` |
| dataIn | input | 1 | Shared data line from the addressed device |
| busAddr | output | 2 | Address lines to the devices |
| rdStrobeN | output | 1 | Active-low read strobe |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| dataOut | output | 1 | Captured data bit |

## Verification
The assertions check, on every cycle, that the strobe is low only while busy and that the address stays still during a transaction. They count the cycles before the strobe falls and the cycles it stays low against the parameter counts. They also check that the done pulse lasts one cycle and comes with the strobe already high. Other behaviours can only be shown by the bench's scenarios. These are the exact edge on which each transition lands and whether the correct bit is captured. The bench models a device that holds the wrong value until its access time has passed, so an early sample is caught. The scenarios also show that requests made during setup or in the done cycle leave no trace.

// File: rtl/busReadSeq_pkg.sv
package busReadSeq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACCESS = 3'd2,
    ST_HOLD   = 3'd3,
    ST_DONE   = 3'd4
  } seqState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadAddr;    // latch request address onto the bus
    logic strobeFall;  // drive read strobe low
    logic strobeRise;  // capture data and release the strobe
    logic doneSet;     // raise the completion pulse
  } ctrlStrobes_t;

  // Round a nanosecond interval up to whole clock cycles, at least one
  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/busReadSeq_ctrl.sv
module busReadSeq_ctrl
  import busReadSeq_pkg::*;
#(
  parameter int SETUP_CYC  = 10,
  parameter int ACCESS_CYC = 55,
  parameter int HOLD_CYC   = 1,
  parameter int CNT_W      = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  localparam logic [CNT_W-1:0] SETUP_LOAD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_LOAD = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD   = CNT_W'(HOLD_CYC - 1);

  seqState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic cntZero;

  assign cntZero = (cntQ == '0);

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.loadAddr = 1'b1;
          stateD = ST_SETUP;
          cntD   = SETUP_LOAD;
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          strobes.strobeFall = 1'b1;
          stateD = ST_ACCESS;
          cntD   = ACCESS_LOAD;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_ACCESS: begin
        if (cntZero) begin
          strobes.strobeRise = 1'b1;
          stateD = ST_HOLD;
          cntD   = HOLD_LOAD;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          strobes.doneSet = 1'b1;
          stateD = ST_DONE;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_DONE: begin
        stateD = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/busReadSeq_dp.sv
module busReadSeq_dp
  import busReadSeq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              rdStrobeN,
  output logic              done,
  output logic [DATA_W-1:0] dataOut
);

  logic [ADDR_W-1:0] addrQ;
  logic              strobeNQ;
  logic              doneQ;
  logic [DATA_W-1:0] captQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strobes.loadAddr) addrQ <= startAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeNQ <= 1'b1;
    else if (strobes.strobeFall) strobeNQ <= 1'b0;
    else if (strobes.strobeRise) strobeNQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captQ <= '0;
    else if (strobes.strobeRise) captQ <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else doneQ <= strobes.doneSet;
  end

  assign busAddr   = addrQ;
  assign rdStrobeN = strobeNQ;
  assign done      = doneQ;
  assign dataOut   = captQ;

endmodule

// File: rtl/busReadSeq.sv
module busReadSeq
  import busReadSeq_pkg::*;
#(
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 1,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETUP_NS      = 100,
  parameter int ACCESS_NS     = 550,
  parameter int HOLD_NS       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              rdStrobeN,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] dataOut
);

  localparam int SETUP_CYC  = cyclesFor(SETUP_NS, CLK_PERIOD_NS);
  localparam int ACCESS_CYC = cyclesFor(ACCESS_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC   = cyclesFor(HOLD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC    = (SETUP_CYC > ACCESS_CYC)
                              ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                              : ((ACCESS_CYC > HOLD_CYC) ? ACCESS_CYC : HOLD_CYC);
  localparam int CNT_W      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  ctrlStrobes_t strobes;

  busReadSeq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .busy   (busy)
  );

  busReadSeq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startAddr(startAddr),
    .dataIn   (dataIn),
    .busAddr  (busAddr),
    .rdStrobeN(rdStrobeN),
    .done     (done),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/busReadSeq_chk.sv
module busReadSeq_chk #(
  parameter int ADDR_W     = 2,
  parameter int SETUP_CYC  = 10,
  parameter int ACCESS_CYC = 55
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rdStrobeN,
  input logic              busy,
  input logic              done
);

  logic [15:0] setupCnt;
  logic [15:0] lowCnt;

  // cycles spent busy with the strobe still high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) setupCnt <= '0;
    else if (!busy) setupCnt <= '0;
    else if (rdStrobeN) setupCnt <= setupCnt + 16'd1;
  end

  // cycles with the strobe held low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (rdStrobeN) lowCnt <= '0;
    else lowCnt <= lowCnt + 16'd1;
  end

  a_r8_strobe_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeN |-> busy);

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(busAddr));

  a_r3_setup_elapsed: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdStrobeN) |-> (setupCnt == 16'(SETUP_CYC)));

  a_r4_access_elapsed: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobeN) |-> (lowCnt == 16'(ACCESS_CYC)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_done_after_release: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdStrobeN && busy));

  a_r7_busy_falls_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind busReadSeq busReadSeq_chk #(
  .ADDR_W    (ADDR_W),
  .SETUP_CYC (SETUP_CYC),
  .ACCESS_CYC(ACCESS_CYC)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .rdStrobeN(rdStrobeN),
  .busy     (busy),
  .done     (done)
);

// File: tb/busReadSeq_tb_top.sv
module busReadSeq_tb_top;

  localparam int CLK_NS = 10;
  localparam int S_CYC  = 10;  // ceil(100/10)  R8
  localparam int A_CYC  = 55;  // ceil(550/10)  R8
  localparam int H_CYC  = 1;   // ceil(5/10) -> 1  R8

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] startAddr = '0;
  logic       dataIn;
  logic [1:0] busAddr;
  logic       rdStrobeN;
  logic       busy;
  logic       done;
  logic       dataOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic devBits [4];
  int   lowCycles = 0;

  typedef struct packed {
    logic [1:0] a;
    logic       d;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_NS/2) clk = ~clk;

  busReadSeq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .dataIn(dataIn), .busAddr(busAddr), .rdStrobeN(rdStrobeN),
    .busy(busy), .done(done), .dataOut(dataOut)
  );

  // Device model: wrong value until the access time has passed
  always @(posedge clk) lowCycles <= rdStrobeN ? 0 : lowCycles + 1;
  always_comb begin
    if (!rdStrobeN && lowCycles >= A_CYC - 1) dataIn = devBits[busAddr];
    else dataIn = ~devBits[busAddr];
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compare completions against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check("R5 unexpected done", 8'd1, 8'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check("R5 captured bit", {7'd0, dataOut}, {7'd0, e.d});
        check("R6 address at done", {6'd0, busAddr}, {6'd0, e.a});
      end
    end
  end

  // probe: 0 none, 1 stray start during setup, 2 stray start in done cycle
  task automatic runTxn(input logic [1:0] a, input int probe);
    expQ.push_back('{a: a, d: devBits[a]});
    @(negedge clk);
    startAddr = a;
    start = 1'b1;
    @(negedge clk);               // after load edge
    start = 1'b0;
    check("R2 busy", {7'd0, busy}, 8'd1);
    check("R2 address", {6'd0, busAddr}, {6'd0, a});
    check("R2 strobe high", {7'd0, rdStrobeN}, 8'd1);
    if (probe == 1) begin
      startAddr = ~a;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R7 ignored start keeps address", {6'd0, busAddr}, {6'd0, a});
      repeat (S_CYC - 2) @(negedge clk);
    end else begin
      repeat (S_CYC - 1) @(negedge clk);
    end
    check("R3 strobe still high", {7'd0, rdStrobeN}, 8'd1);
    @(negedge clk);
    check("R3 strobe low after setup", {7'd0, rdStrobeN}, 8'd0);
    repeat (A_CYC - 1) @(negedge clk);
    check("R4 strobe still low", {7'd0, rdStrobeN}, 8'd0);
    @(negedge clk);
    check("R4 strobe released", {7'd0, rdStrobeN}, 8'd1);
    check("R5 no done during hold", {7'd0, done}, 8'd0);
    check("R6 address held", {6'd0, busAddr}, {6'd0, a});
    repeat (H_CYC) @(negedge clk);
    check("R5 done pulse", {7'd0, done}, 8'd1);
    check("R7 busy in done cycle", {7'd0, busy}, 8'd1);
    if (probe == 2) begin
      startAddr = ~a;
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    check("R5 done one cycle", {7'd0, done}, 8'd0);
    check("R7 busy low", {7'd0, busy}, 8'd0);
    check("R6 address after done", {6'd0, busAddr}, {6'd0, a});
    if (probe == 2) begin
      @(negedge clk);
      check("R7 done-cycle start dropped", {7'd0, busy}, 8'd0);
      check("R5 dataOut kept", {7'd0, dataOut}, {7'd0, devBits[a]});
    end
  endtask

  initial begin
    devBits[0] = 1'b1; devBits[1] = 1'b0; devBits[2] = 1'b1; devBits[3] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 strobe", {7'd0, rdStrobeN}, 8'd1);
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 done", {7'd0, done}, 8'd0);
    check("R1 address", {6'd0, busAddr}, 8'd0);
    check("R1 dataOut", {7'd0, dataOut}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {7'd0, busy}, 8'd0);
    runTxn(2'd2, 0);
    runTxn(2'd1, 1);
    runTxn(2'd0, 2);
    runTxn(2'd3, 0);
    devBits[3] = 1'b1;
    runTxn(2'd3, 1);
    devBits[1] = 1'b1;
    runTxn(2'd1, 2);
    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", 8'(expQ.size()), 8'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule